// File: doc/BRIEF.md
# Parallel Port Mode and Control Register

This block is the host-visible mode and control register of an enhanced parallel port controller. It holds a 3-bit operating-mode code and three control bits: an error-interrupt disable, a DMA enable and a service mask. It also shows the two FIFO status flags as read-only bits. The mode code is decoded into one-hot select lines for the controller's datapaths. The reserved code selects no datapath.

A FAULT input from the peripheral cable is synchronised and watched for falling edges. While the extended-capability (ECP) mode is active and the error interrupt is allowed, such an edge latches a sticky error request. Any read of the register clears that request. The FIFO threshold request from the datapath goes to exactly one place. It drives a service interrupt when DMA is off, and a DMA request when DMA is on. The mask bit suppresses both. The single interrupt output is the OR of the error and service requests.

Top module: `ppx_ctl`

## Requirements
- R1: After reset, rdata[7:2] reads 6'b000101: mode 000, error disable bit 4 = 1, DMA enable bit 3 = 0, service mask bit 2 = 1. irq and dma_req are 0.
- R2: A write stores wdata[7:2] into bits 7..2, and reads return them in the following cycle. rdata[1] always equals fifo_full and rdata[0] always equals fifo_empty. Written values of bits 1 and 0 are ignored.
- R3: mode_sel is one-hot. Bit m is set when the stored mode code in bits 7..5 equals m. Codes are 000 standard, 001 bidirectional, 010 FIFO, 011 ECP, 100 EPP, 110 FIFO test and 111 configuration.
- R4: Code 101 (reserved) is stored and read back as written, but drives mode_sel to all zeros.
- R5: A falling edge on fault_n while the mode is 011 and bit 4 is 0 sets the error request. irq rises after the third rising clock edge that samples fault_n low, and not after the second.
- R6: A falling edge of fault_n in any other mode, or with bit 4 = 1, does not raise irq. A rising edge never raises irq.
- R7: The error request is sticky while fault_n returns high. It is cleared by the clock edge at which rd_en is sampled high.
- R8: With bit 2 = 0 and bit 3 = 0, irq follows fifo_req combinationally and dma_req stays 0.
- R9: With bit 2 = 0 and bit 3 = 1, dma_req follows fifo_req and the service part of irq stays 0.
- R10: With bit 2 = 1, both dma_req and the service interrupt are 0 whatever fifo_req and bit 3 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clears error request |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: mode, control bits, full, empty |
| fifo_full | input | 1 | FIFO full flag from datapath |
| fifo_empty | input | 1 | FIFO empty flag from datapath |
| fifo_req | input | 1 | FIFO threshold service request |
| fault_n | input | 1 | Asynchronous active-low peripheral fault |
| mode_sel | output | 8 | One-hot datapath select, indexed by mode code |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is an error request that is latched while its gates are open and then has to be seen to persist or clear. This is only reachable through the asynchronous fault_n pin, and it passes through the synchroniser delay. The bench first selects each of the eight modes with both values of bit 4. It then drops fault_n and checks irq one edge before and exactly at the expected edge. Next it raises fault_n to show that the request is sticky, and finally it issues a read strobe to show the clear. Separate sweeps cover every written byte against all status combinations, and the full truth table of mask, enable and request.

// File: rtl/ppx_pkg.sv
package ppx_pkg;
  localparam int MODE_W  = 3;
  localparam int NUM_MODES = 1 << MODE_W;
  localparam int CTRL_W  = 6;
  localparam int DATA_W  = 8;

  typedef enum logic [MODE_W-1:0] {
    PM_STD   = 3'd0,
    PM_BIDIR = 3'd1,
    PM_FIFO  = 3'd2,
    PM_ECP   = 3'd3,
    PM_EPP   = 3'd4,
    PM_RSVD  = 3'd5,
    PM_TEST  = 3'd6,
    PM_CFG   = 3'd7
  } pmode_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              err_dis;
    logic              dma_en;
    logic              svc_mask;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{mode: PM_STD, err_dis: 1'b1, dma_en: 1'b0, svc_mask: 1'b1};
endpackage

// File: rtl/ppx_fault_detect.sv
module ppx_fault_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_n,
  output logic fall
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= fault_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[SYNC_STAGES-1];

  assign fall = prev & ~chain[SYNC_STAGES-1];

  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R5
endmodule

// File: rtl/ppx_ctrl_reg.sv
module ppx_ctrl_reg
  import ppx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 fifo_full,
  input  logic                 fifo_empty,
  output ctrl_t                ctrl,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_MODES-1:0] mode_sel
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ctrl <= CTRL_RST;
    else if (wr_en) ctrl <= ctrl_t'(wdata[DATA_W-1:DATA_W-CTRL_W]);

  assign rdata = {ctrl, fifo_full, fifo_empty};

  genvar m;
  generate
    for (m = 0; m < NUM_MODES; m++) begin : g_dec
      if (m == int'(PM_RSVD)) begin : g_none
        assign mode_sel[m] = 1'b0;
      end else begin : g_hit
        assign mode_sel[m] = (ctrl.mode == MODE_W'(m));
      end
    end
  endgenerate

  always_comb begin
    if (rst_n) begin
      AST_STATUS_PASS: assert (rdata[1:0] == {fifo_full, fifo_empty}); // R2
    end
  end

  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_sel)); // R3
  AST_RSVD_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == PM_RSVD) |-> (mode_sel == '0)); // R4
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[DATA_W-1:2] == $past(wdata[DATA_W-1:2]))); // R2
endmodule

// File: rtl/ppx_req_gate.sv
module ppx_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic ecp_on,
  input  logic err_dis,
  input  logic dma_en,
  input  logic svc_mask,
  input  logic fifo_req,
  input  logic rd_en,
  output logic irq,
  output logic dma_req
);
  logic err_pend;
  logic err_irq;
  logic svc_irq;
  logic err_open;

  assign err_open = ecp_on & ~err_dis;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 err_pend <= 1'b0;
    else if (fall && err_open)  err_pend <= 1'b1;
    else if (rd_en)             err_pend <= 1'b0;

  assign err_irq = err_pend & err_open;
  assign svc_irq = fifo_req & ~svc_mask & ~dma_en;
  assign dma_req = fifo_req & ~svc_mask & dma_en;
  assign irq     = err_irq | svc_irq;

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fall) |=> !err_pend); // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pend && !rd_en) |=> err_pend); // R7
  AST_PEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_pend && !(fall && err_open)) |=> !err_pend); // R6
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    svc_mask |-> (!dma_req && !svc_irq)); // R10
  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && svc_irq)); // R9
  AST_DMA_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> fifo_req); // R8
endmodule

// File: rtl/ppx_ctl.sv
module ppx_ctl
  import ppx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic                 fifo_full,
  input  logic                 fifo_empty,
  input  logic                 fifo_req,
  input  logic                 fault_n,
  output logic [NUM_MODES-1:0] mode_sel,
  output logic                 dma_req,
  output logic                 irq
);
  ctrl_t ctrl;
  logic  fall;

  ppx_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .ctrl(ctrl), .rdata(rdata), .mode_sel(mode_sel)
  );

  ppx_fault_detect #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
    .clk(clk), .rst_n(rst_n), .fault_n(fault_n), .fall(fall)
  );

  ppx_req_gate u_gate (
    .clk(clk), .rst_n(rst_n), .fall(fall),
    .ecp_on(mode_sel[int'(PM_ECP)]), .err_dis(ctrl.err_dis),
    .dma_en(ctrl.dma_en), .svc_mask(ctrl.svc_mask),
    .fifo_req(fifo_req), .rd_en(rd_en),
    .irq(irq), .dma_req(dma_req)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && !dma_req)); // R1
endmodule

// File: tb/ppx_ctl_test.sv
module ppx_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       fifo_full = 1'b0, fifo_empty = 1'b1, fifo_req = 1'b0, fault_n = 1'b1;
  logic [7:0] mode_sel;
  logic       dma_req, irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ppx_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fifo_req(fifo_req), .fault_n(fault_n), .mode_sel(mode_sel),
    .dma_req(dma_req), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_sel(input logic [2:0] m);
    return (m == 3'd5) ? 8'h00 : (8'h01 << m);
  endfunction

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cycles(3);
    #1 rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    check("R1 ctrl bits", rdata[7:2], 6'b000101);
    check("R1 irq", irq, 0);
    check("R1 dma_req", dma_req, 0);
    fifo_req = 1'b1; #1;
    check("R1 masked req irq", irq, 0);
    check("R1 masked req dma", dma_req, 0);
    fifo_req = 1'b0;

    // R2 R3 R4 readback sweep
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      for (int s = 0; s < 4; s++) begin
        fifo_full = s[1]; fifo_empty = s[0]; #1;
        check("R2 readback", rdata, {8'(v) & 8'hFC} | 8'(s));
      end
      if (v[7:5] == 3'd5) check("R4 reserved select", mode_sel, 8'h00);
      else                check("R3 mode select", mode_sel, exp_sel(3'(v >> 5)));
    end

    // R8 R9 R10 gating truth table
    for (int g = 0; g < 8; g++) begin
      logic dma, msk, rq;
      dma = g[2]; msk = g[1]; rq = g[0];
      wr({3'b000, 1'b1, dma, msk, 2'b00});
      fifo_req = rq; #1;
      if (msk) begin
        check("R10 irq masked", irq, 0);
        check("R10 dma masked", dma_req, 0);
      end else if (dma) begin
        check("R9 dma follows req", dma_req, rq);
        check("R9 irq quiet", irq, 0);
      end else begin
        check("R8 irq follows req", irq, rq);
        check("R8 dma quiet", dma_req, 0);
      end
      @(negedge clk); fifo_req = 1'b0;
    end

    // R5 R6 R7 fault edge sweep
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 2; d++) begin
        logic want;
        want = (m == 3) && (d == 0);
        wr({3'(m), 1'(d), 1'b0, 1'b1, 2'b00});
        fault_n = 1'b1; cycles(4); rd_pulse();
        check("R7 clear before test", irq, 0);
        @(negedge clk); fault_n = 1'b0;
        cycles(2);
        check("R5 not yet after 2 edges", irq, 0);
        cycles(1);
        if (want) check("R5 irq on fault fall", irq, 1);
        else      check("R6 ignored fall", irq, 0);
        fault_n = 1'b1; cycles(4);
        check("R7 sticky after rise", irq, want);
        rd_pulse();
        check("R7 cleared by read", irq, 0);
      end
    end

    // R6 rising edge in open ECP mode
    wr({3'd3, 1'b0, 1'b0, 1'b1, 2'b00});
    @(negedge clk); fault_n = 1'b0; cycles(4); rd_pulse();
    check("R7 clear while low", irq, 0);
    @(negedge clk); fault_n = 1'b1; cycles(4);
    check("R6 rising edge ignored", irq, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule